// File: doc/BRIEF.md
# Legacy Virtio Control Register Window

This block is the byte-addressed control register file of a legacy-style virtio device that serves several virtqueues. Host software reads the feature bits offered by the device and writes back the subset it wants. It selects a queue, gives the page frame of that queue's ring memory, moves the device status through its stages, and reads and clears the interrupt status. The block turns these register accesses into plain control pulses for the rest of the device: a per-queue notify strobe, a device-reset pulse and a driver-ready pulse. It also derives the three ring base addresses of every queue from the page frame number that was written.

The queue engines report interrupt causes as single-cycle pulses. Each cause is accumulated into the interrupt status byte and asserts a level interrupt line. Reading that byte returns its contents, clears it and drops the line. Accesses use a read strobe or a write strobe together with an offset, a byte count and write data. Read data comes back from a register one cycle later, qualified by a valid bit. The register bus is a plain strobe interface with no back-pressure: every access completes in one cycle. The cause input is also a plain pulse vector that cannot be refused. Device-specific configuration space starting at offset 0x14 is out of scope and reads as zero.

Top module: `vq_reg_window`

## Requirements
- R1: A 4-byte read at offset 0x00 returns the host feature mask with bit 24 (notify-on-empty) and bit 30 (bad-feature marker) forced to one.
- R2: A 4-byte write at 0x04 stores one of three values. With bit 30 set, it stores the minimal feature set. With any bit that the offered mask (host mask plus bit 24) lacks, it stores the offered mask. Otherwise it stores the written value. A 4-byte read at 0x04 returns the stored value.
- R3: A 2-byte write at 0x0E updates the queue selector only when its low 16 bits are below the number of queues; otherwise the selector keeps its value. A 2-byte read at 0x0E returns the selector.
- R4: A nonzero 4-byte write at 0x08 sets the page frame number of the selected queue, which a 4-byte read at 0x08 returns. The queue's bases become: descriptor = pfn shifted left by the page shift; available = descriptor + 16*depth; used = (available + 4 + 2*depth) rounded up to a page boundary.
- R5: A zero written to the page frame register, or a zero byte written to status at 0x12, pulses dev_reset for one cycle. It clears the guest features, the selector, the status, the interrupt status, the line and the ring state of every queue.
- R6: drv_ready pulses for one cycle only on a 1-byte status write whose bit 2 is set while the stored status has bit 2 clear. The status byte is readable at 0x12.
- R7: Any nonzero irq_cause is ORed into the interrupt status, and irq is high in the cycle after the pulse.
- R8: A 1-byte read at 0x13 returns the accumulated cause bits, clears them and drops irq. A cause arriving in the same cycle as the read survives it and keeps irq high.
- R9: A 2-byte write at 0x10 pulses notify[i] for one cycle only when the written index i is below the number of queues and queue i has a nonzero descriptor base.
- R10: A read below 0x14 that hits no register at its exact width, or hits the write-only notify register, returns all ones. A read at 0x14 or above returns zero.
- R11: A 2-byte read at 0x0C returns the configured queue depth.
- R12: rd_valid is high exactly one cycle after each read strobe, with rd_data valid in that cycle.
- R13: A write whose byte count differs from the width of its register (4 at 0x00..0x08, 2 at 0x0C..0x10, 1 at 0x12..0x13) changes nothing and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_off | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Byte count of the access (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Qualifies rd_data |
| irq_cause | input | 8 | Interrupt cause pulses from the queue engines |
| irq | output | 1 | Level interrupt line |
| notify | output | NUM_Q | Per-queue notify strobe |
| dev_reset | output | 1 | Device reset pulse |
| drv_ready | output | 1 | Driver-ready pulse |
| desc_base | output | NUM_Q*ADDR_W | Descriptor table base of each queue, queue 0 lowest |
| avail_base | output | NUM_Q*ADDR_W | Available ring base of each queue |
| used_base | output | NUM_Q*ADDR_W | Used ring base of each queue |

## Verification
The read-to-clear of the interrupt status byte and a new cause pulse can land on the same clock edge. A lost cause would leave the host waiting forever. The bench drives an interrupt status read and a fresh cause pulse on the same edge. It expects the read to return only the older bits, irq to stay high, and a second read to return exactly the newer cause before irq falls.

// File: rtl/vqw_pkg.sv
package vqw_pkg;

  localparam int unsigned OFF_W   = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ISR_W   = 8;
  localparam int unsigned DRV_OK_BIT = 2;

  localparam logic [OFF_W-1:0] OFF_HOST_FEAT  = 8'h00;
  localparam logic [OFF_W-1:0] OFF_GUEST_FEAT = 8'h04;
  localparam logic [OFF_W-1:0] OFF_PFN        = 8'h08;
  localparam logic [OFF_W-1:0] OFF_QSIZE      = 8'h0C;
  localparam logic [OFF_W-1:0] OFF_QSEL       = 8'h0E;
  localparam logic [OFF_W-1:0] OFF_NOTIFY     = 8'h10;
  localparam logic [OFF_W-1:0] OFF_STATUS     = 8'h12;
  localparam logic [OFF_W-1:0] OFF_ISR        = 8'h13;
  localparam logic [OFF_W-1:0] OFF_CFG        = 8'h14;

  typedef enum logic [3:0] {
    RS_NONE, RS_HOSTF, RS_GUESTF, RS_PFN, RS_QSIZE,
    RS_QSEL, RS_NOTIFY, RS_STATUS, RS_ISR, RS_CFG
  } reg_sel_e;

  function automatic reg_sel_e decode_reg(input logic [OFF_W-1:0] off,
                                          input logic [2:0] sz);
    reg_sel_e r;
    r = RS_NONE;
    if (off >= OFF_CFG) begin
      r = RS_CFG;
    end else begin
      case (off)
        OFF_HOST_FEAT:  if (sz == 3'd4) r = RS_HOSTF;
        OFF_GUEST_FEAT: if (sz == 3'd4) r = RS_GUESTF;
        OFF_PFN:        if (sz == 3'd4) r = RS_PFN;
        OFF_QSIZE:      if (sz == 3'd2) r = RS_QSIZE;
        OFF_QSEL:       if (sz == 3'd2) r = RS_QSEL;
        OFF_NOTIFY:     if (sz == 3'd2) r = RS_NOTIFY;
        OFF_STATUS:     if (sz == 3'd1) r = RS_STATUS;
        OFF_ISR:        if (sz == 3'd1) r = RS_ISR;
        default:        r = RS_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/vqw_feat_neg.sv
module vqw_feat_neg #(
  parameter logic [31:0] HOST_FEAT = 32'h0000_0021,
  parameter logic [31:0] MIN_FEAT  = 32'h0000_0001,
  parameter int unsigned NOE_BIT   = 24,
  parameter int unsigned BAD_BIT   = 30
) (
  input  logic [31:0] req,
  output logic [31:0] granted,
  output logic [31:0] host_adv
);
  localparam logic [31:0] OFFERED = HOST_FEAT | (32'd1 << NOE_BIT);

  assign host_adv = OFFERED | (32'd1 << BAD_BIT);

  always_comb begin
    if (req[BAD_BIT])
      granted = MIN_FEAT;
    else if ((req & ~OFFERED) != '0)
      granted = OFFERED;
    else
      granted = req;
  end
endmodule

// File: rtl/vqw_ring_slot.sv
module vqw_ring_slot #(
  parameter int unsigned Q_DEPTH    = 256,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PFN_W      = 32,
  localparam int unsigned ADDR_W    = PFN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [PFN_W-1:0]  pfn_in,
  output logic [PFN_W-1:0]  pfn_o,
  output logic              live_o,
  output logic [ADDR_W-1:0] desc_o,
  output logic [ADDR_W-1:0] avail_o,
  output logic [ADDR_W-1:0] used_o
);
  localparam logic [ADDR_W-1:0] DESC_BYTES  = ADDR_W'(16 * Q_DEPTH);
  localparam logic [ADDR_W-1:0] AVAIL_BYTES = ADDR_W'(4 + 2 * Q_DEPTH);
  localparam logic [ADDR_W-1:0] PAGE_MASK   = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

  logic [PFN_W-1:0]  pfn_q;
  logic [ADDR_W-1:0] avail_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pfn_q <= '0;
    else if (clr)  pfn_q <= '0;
    else if (load) pfn_q <= pfn_in;
  end

  assign live_o    = (pfn_q != '0);
  assign pfn_o     = pfn_q;
  assign desc_o    = live_o ? {pfn_q, {PAGE_SHIFT{1'b0}}} : '0;
  assign avail_o   = live_o ? desc_o + DESC_BYTES : '0;
  assign avail_end = avail_o + AVAIL_BYTES + PAGE_MASK;
  assign used_o    = live_o ? (avail_end & ~PAGE_MASK) : '0;
endmodule

// File: rtl/vqw_isr.sv
module vqw_isr #(
  parameter int unsigned ISR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ISR_W-1:0] cause,
  input  logic             rd_clr,
  input  logic             soft_clr,
  output logic [ISR_W-1:0] isr_o,
  output logic             irq_o
);
  logic [ISR_W-1:0] isr_q;
  logic             irq_q;
  logic             wipe;

  assign wipe = rd_clr | soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      isr_q <= (wipe ? '0 : isr_q) | cause;
      if (cause != '0)  irq_q <= 1'b1;
      else if (wipe)    irq_q <= 1'b0;
    end
  end

  assign isr_o = isr_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/vq_reg_window.sv
module vq_reg_window
  import vqw_pkg::*;
#(
  parameter int unsigned NUM_Q      = 3,
  parameter int unsigned Q_DEPTH    = 256,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter logic [31:0] HOST_FEAT  = 32'h0000_0021,
  parameter logic [31:0] MIN_FEAT   = 32'h0000_0001,
  parameter int unsigned NOE_BIT    = 24,
  parameter int unsigned BAD_BIT    = 30,
  localparam int unsigned ADDR_W    = DATA_W + PAGE_SHIFT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  input  logic [OFF_W-1:0]        bus_off,
  input  logic [2:0]              bus_size,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid,
  input  logic [ISR_W-1:0]        irq_cause,
  output logic                    irq,
  output logic [NUM_Q-1:0]        notify,
  output logic                    dev_reset,
  output logic                    drv_ready,
  output logic [NUM_Q*ADDR_W-1:0] desc_base,
  output logic [NUM_Q*ADDR_W-1:0] avail_base,
  output logic [NUM_Q*ADDR_W-1:0] used_base
);
  localparam int unsigned SEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  reg_sel_e           rsel, wsel;
  logic [DATA_W-1:0]  guest_q, granted, host_adv;
  logic [SEL_W-1:0]   sel_q;
  logic [7:0]         status_q;
  logic [ISR_W-1:0]   isr;
  logic [DATA_W-1:0]  slot_pfn [NUM_Q];
  logic [NUM_Q-1:0]   slot_live, pfn_load, nfy_next;
  logic               soft_rst, rdy_next, qsel_ok, isr_rd;
  logic [DATA_W-1:0]  rd_next;
  logic [DATA_W-1:0]  rd_data_q;
  logic               rd_valid_q, rst_pulse_q, rdy_q;
  logic [NUM_Q-1:0]   nfy_q;

  assign rsel = decode_reg(bus_off, bus_size);
  assign wsel = bus_wr ? rsel : RS_NONE;

  assign soft_rst = (wsel == RS_PFN    && bus_wdata == '0) ||
                    (wsel == RS_STATUS && bus_wdata[7:0] == 8'h00);
  assign qsel_ok  = (bus_wdata[15:0] < 16'(NUM_Q));
  assign rdy_next = (wsel == RS_STATUS) && (bus_wdata[7:0] != 8'h00) &&
                    !status_q[DRV_OK_BIT] && bus_wdata[DRV_OK_BIT];
  assign isr_rd   = bus_rd && (rsel == RS_ISR);

  vqw_feat_neg #(
    .HOST_FEAT(HOST_FEAT), .MIN_FEAT(MIN_FEAT),
    .NOE_BIT(NOE_BIT), .BAD_BIT(BAD_BIT)
  ) u_feat (
    .req(bus_wdata), .granted(granted), .host_adv(host_adv)
  );

  vqw_isr #(.ISR_W(ISR_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .cause(irq_cause),
    .rd_clr(isr_rd), .soft_clr(soft_rst), .isr_o(isr), .irq_o(irq)
  );

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      pfn_load[q] = (wsel == RS_PFN) && (bus_wdata != '0) && (sel_q == SEL_W'(q));
      nfy_next[q] = (wsel == RS_NOTIFY) && (bus_wdata[15:0] == 16'(q)) && slot_live[q];
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
    vqw_ring_slot #(
      .Q_DEPTH(Q_DEPTH), .PAGE_SHIFT(PAGE_SHIFT), .PFN_W(DATA_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(pfn_load[q]),
      .pfn_in(bus_wdata), .pfn_o(slot_pfn[q]), .live_o(slot_live[q]),
      .desc_o(desc_base[q*ADDR_W +: ADDR_W]),
      .avail_o(avail_base[q*ADDR_W +: ADDR_W]),
      .used_o(used_base[q*ADDR_W +: ADDR_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guest_q  <= '0;
      sel_q    <= '0;
      status_q <= '0;
    end else if (soft_rst) begin
      guest_q  <= '0;
      sel_q    <= '0;
      status_q <= '0;
    end else begin
      if (wsel == RS_GUESTF)           guest_q  <= granted;
      if (wsel == RS_QSEL && qsel_ok)  sel_q    <= bus_wdata[SEL_W-1:0];
      if (wsel == RS_STATUS)           status_q <= bus_wdata[7:0];
    end
  end

  always_comb begin
    case (rsel)
      RS_HOSTF:  rd_next = host_adv;
      RS_GUESTF: rd_next = guest_q;
      RS_PFN:    rd_next = slot_pfn[sel_q];
      RS_QSIZE:  rd_next = DATA_W'(Q_DEPTH);
      RS_QSEL:   rd_next = DATA_W'(sel_q);
      RS_STATUS: rd_next = DATA_W'(status_q);
      RS_ISR:    rd_next = DATA_W'(isr);
      RS_CFG:    rd_next = '0;
      default:   rd_next = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q   <= '0;
      rd_valid_q  <= 1'b0;
      rst_pulse_q <= 1'b0;
      rdy_q       <= 1'b0;
      nfy_q       <= '0;
    end else begin
      rd_valid_q  <= bus_rd;
      if (bus_rd) rd_data_q <= rd_next;
      rst_pulse_q <= soft_rst;
      rdy_q       <= rdy_next;
      nfy_q       <= nfy_next;
    end
  end

  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;
  assign dev_reset = rst_pulse_q;
  assign drv_ready = rdy_q;
  assign notify    = nfy_q;
endmodule

// File: rtl/vq_reg_window_chk.sv
module vq_reg_window_chk
  import vqw_pkg::*;
#(
  parameter int unsigned NUM_Q = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [OFF_W-1:0] bus_off,
  input logic [2:0]       bus_size,
  input logic [31:0]      bus_wdata,
  input logic             rd_valid,
  input logic [ISR_W-1:0] irq_cause,
  input logic             irq,
  input logic [NUM_Q-1:0] notify,
  input logic             dev_reset,
  input logic             drv_ready
);
  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);
  p_no_spurious_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);
  p_cause_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cause != '0) |=> irq);
  p_isr_read_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_off == OFF_ISR && bus_size == 3'd1 && irq_cause == '0) |=> !irq);
  p_notify_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(notify));
  p_notify_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (notify != '0) |-> $past(bus_wr && bus_off == OFF_NOTIFY && bus_size == 3'd2));
  p_ready_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_ready |-> $past(bus_wr && bus_off == OFF_STATUS && bus_wdata[DRV_OK_BIT]));
  p_reset_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> $past(bus_wr && (bus_off == OFF_PFN || bus_off == OFF_STATUS)));
  p_ready_reset_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_ready && dev_reset));
endmodule

bind vq_reg_window vq_reg_window_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_off(bus_off), .bus_size(bus_size), .bus_wdata(bus_wdata),
  .rd_valid(rd_valid), .irq_cause(irq_cause), .irq(irq),
  .notify(notify), .dev_reset(dev_reset), .drv_ready(drv_ready)
);

// File: tb/test_vq_reg_window.sv
`timescale 1ns/1ps
module test_vq_reg_window;
  localparam int NQ = 3;
  localparam int AW = 44;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_off = '0;
  logic [2:0]    bus_size = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic [7:0]    irq_cause = '0;
  logic          irq;
  logic [NQ-1:0] notify;
  logic          dev_reset, drv_ready;
  logic [NQ*AW-1:0] desc_base, avail_base, used_base;

  vq_reg_window #(.NUM_Q(NQ)) i_vq_reg_window (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_off(bus_off), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_cause(irq_cause),
    .irq(irq), .notify(notify), .dev_reset(dev_reset), .drv_ready(drv_ready),
    .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bwrite(logic [7:0] off, logic [2:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_off = off; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(logic [7:0] off, logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_off = off; bus_size = sz;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    chk("reset irq R7", irq, 0);
    chk("reset pulses R5", {dev_reset, drv_ready, notify}, 0);
    bread(8'h04, 3'd4, v); chk("reset guest R5", v, 0);
    chk("read valid R12", rd_valid, 1);
    @(negedge clk); chk("valid drops R12", rd_valid, 0);
    bread(8'h0E, 3'd2, v); chk("reset sel R5", v, 0);
    bread(8'h12, 3'd1, v); chk("reset status R5", v, 0);
    bread(8'h13, 3'd1, v); chk("reset isr R8", v, 0);
  endtask

  task automatic t_features();
    logic [31:0] v;
    bread(8'h00, 3'd4, v); chk("host features R1", v, 32'h4100_0021);
    bwrite(8'h04, 3'd4, 32'h0000_0021); bread(8'h04, 3'd4, v);
    chk("guest plain R2", v, 32'h0000_0021);
    bwrite(8'h04, 3'd4, 32'h0100_0001); bread(8'h04, 3'd4, v);
    chk("guest noe R2", v, 32'h0100_0001);
    bwrite(8'h04, 3'd4, 32'h0000_0002); bread(8'h04, 3'd4, v);
    chk("guest unsupported R2", v, 32'h0100_0021);
    bwrite(8'h04, 3'd4, 32'h4000_0021); bread(8'h04, 3'd4, v);
    chk("guest bad marker R2", v, 32'h0000_0001);
  endtask

  task automatic t_qsel_size();
    logic [31:0] v;
    bwrite(8'h0E, 3'd2, 32'd2); bread(8'h0E, 3'd2, v); chk("sel valid R3", v, 2);
    bwrite(8'h0E, 3'd2, 32'd3); bread(8'h0E, 3'd2, v); chk("sel out of range R3", v, 2);
    bwrite(8'h0E, 3'd4, 32'd1); bread(8'h0E, 3'd2, v); chk("sel wrong size R13", v, 2);
    bread(8'h0C, 3'd2, v); chk("queue depth R11", v, 256);
  endtask

  task automatic t_pfn_bases();
    logic [31:0] v;
    bwrite(8'h0E, 3'd2, 32'd1);
    bwrite(8'h08, 3'd4, 32'h12);
    bread(8'h08, 3'd4, v); chk("pfn readback R4", v, 32'h12);
    chk("desc q1 R4",  desc_base[1*AW +: AW],  44'h12000);
    chk("avail q1 R4", avail_base[1*AW +: AW], 44'h13000);
    chk("used q1 R4",  used_base[1*AW +: AW],  44'h14000);
    chk("desc q0 untouched R4", desc_base[0 +: AW], 0);
    bwrite(8'h0E, 3'd2, 32'd2);
    bwrite(8'h08, 3'd4, 32'h5);
    chk("used q2 R4", used_base[2*AW +: AW], 44'h7000);
    bread(8'h08, 3'd4, v); chk("pfn q2 readback R4", v, 32'h5);
  endtask

  task automatic t_notify();
    bwrite(8'h10, 3'd2, 32'd2); chk("notify live q2 R9", notify, 3'b100);
    @(negedge clk); chk("notify one cycle R9", notify, 0);
    bwrite(8'h10, 3'd2, 32'd0); chk("notify uninit q0 R9", notify, 0);
    bwrite(8'h10, 3'd2, 32'd7); chk("notify bad index R9", notify, 0);
    bwrite(8'h10, 3'd2, 32'd1); chk("notify live q1 R9", notify, 3'b010);
  endtask

  task automatic t_status_ready();
    logic [31:0] v;
    bwrite(8'h12, 3'd1, 32'h01); chk("no ready without bit2 R6", drv_ready, 0);
    bwrite(8'h12, 3'd1, 32'h05); chk("ready on rise R6", drv_ready, 1);
    @(negedge clk); chk("ready one cycle R6", drv_ready, 0);
    bwrite(8'h12, 3'd1, 32'h07); chk("no ready when held R6", drv_ready, 0);
    bread(8'h12, 3'd1, v); chk("status readback R6", v, 32'h07);
    bwrite(8'h12, 3'd4, 32'h00); chk("wrong size no reset R13", dev_reset, 0);
    bread(8'h12, 3'd1, v); chk("status kept R13", v, 32'h07);
  endtask

  task automatic t_status_reset();
    logic [31:0] v;
    bwrite(8'h04, 3'd4, 32'h21);
    bwrite(8'h12, 3'd1, 32'h00);
    chk("status zero reset R5", dev_reset, 1);
    chk("status zero no ready R6", drv_ready, 0);
    chk("bases cleared R5", {desc_base, used_base}, 0);
    bread(8'h04, 3'd4, v); chk("guest cleared R5", v, 0);
    bread(8'h0E, 3'd2, v); chk("sel cleared R5", v, 0);
  endtask

  task automatic t_pfn_reset();
    logic [31:0] v;
    bwrite(8'h12, 3'd1, 32'h04);
    bwrite(8'h0E, 3'd2, 32'd1);
    bwrite(8'h08, 3'd4, 32'h12);
    chk("q1 set before R4", desc_base[1*AW +: AW], 44'h12000);
    bwrite(8'h08, 3'd4, 32'h0);
    chk("pfn zero reset R5", dev_reset, 1);
    chk("q1 cleared R5", desc_base[1*AW +: AW], 0);
    bread(8'h12, 3'd1, v); chk("status cleared R5", v, 0);
  endtask

  task automatic t_isr();
    logic [31:0] v;
    @(negedge clk); irq_cause = 8'h01;
    @(negedge clk); irq_cause = 8'h00;
    chk("irq after cause R7", irq, 1);
    @(negedge clk); irq_cause = 8'h04;
    @(negedge clk); irq_cause = 8'h00;
    bread(8'h13, 3'd1, v); chk("isr accumulated R8", v, 32'h05);
    chk("irq dropped R8", irq, 0);
    bread(8'h13, 3'd1, v); chk("isr cleared R8", v, 0);
  endtask

  task automatic t_isr_race();
    logic [31:0] v;
    @(negedge clk); irq_cause = 8'h01;
    @(negedge clk); irq_cause = 8'h02;
    bus_rd = 1'b1; bus_off = 8'h13; bus_size = 3'd1;
    @(negedge clk); irq_cause = 8'h00; bus_rd = 1'b0;
    chk("race read old bits R8", rd_data, 32'h01);
    chk("race irq kept R8", irq, 1);
    bread(8'h13, 3'd1, v); chk("race new cause kept R8", v, 32'h02);
    chk("race irq dropped R8", irq, 0);
  endtask

  task automatic t_undefined();
    logic [31:0] v;
    bread(8'h01, 3'd1, v); chk("undef offset R10", v, 32'hFFFF_FFFF);
    bread(8'h10, 3'd2, v); chk("notify unreadable R10", v, 32'hFFFF_FFFF);
    bread(8'h13, 3'd4, v); chk("isr wrong size R10", v, 32'hFFFF_FFFF);
    bread(8'h20, 3'd4, v); chk("config area R10", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_features();
    t_qsel_size();
    t_pfn_bases();
    t_notify();
    t_status_ready();
    t_status_reset();
    t_pfn_reset();
    t_isr();
    t_isr_race();
    t_undefined();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule